// File: doc/BRIEF.md
# Synchronous Burst Pseudo-Static RAM Host Controller

This block sits between an on-chip requester and a 16-bit pseudo-static RAM that is run in synchronous burst mode. The requester hands over one transaction at a time through a valid/ready handshake. A transaction holds a 21-bit word address, a direction, a word count and two byte enables. The controller turns it into one or more clocked bursts. Each burst opens with a single-clock address strobe and then moves one data word on every clock in which the memory's WAIT input is low.

The memory refreshes itself in the background. It needs the chip enable to return high at regular intervals, and it may stall a burst at any point by raising WAIT. The controller therefore keeps a count of how long chip enable has been low. Once that count reaches a limit derived from a nanosecond budget, the burst is closed even if words are still owed. The controller then holds chip enable high for a minimum gap and reopens the burst at the next word address. No word is lost or repeated. Read data returns with a valid strobe and a last flag. Write data is pulled from the requester one word per take strobe.

Top module: `psram_burst_ctl`

## Requirements
- R1: During reset and for `STARTUP_CYC` clocks after reset is released, `mem_ce_n` is high and `req_ready` is low. `req_ready` first goes high on the clock after that, with `mem_adv_n` high and `rd_valid` low throughout.
- R2: On the clock after a request is accepted, `mem_ce_n` goes low and `mem_adv_n` is low for exactly one clock. `mem_addr` carries the request address and `mem_we_n` is the inverse of `req_write`. `mem_adv_n` is never low while `mem_ce_n` is high.
- R3: `mem_wait` is active high. A word moves only on a clock where `mem_ce_n` is low, `mem_adv_n` is high and `mem_wait` is low. Every clock with `mem_wait` high adds one clock to the burst.
- R4: For a read, each word sampled from `mem_dq_i` appears on `rd_data` with `rd_valid` high one clock after the clock that moved it, in address order. `rd_last` is high only with the final word.
- R5: During a write burst `mem_dq_oe` is high and `mem_dq_o` equals `wr_data`. `wr_take` is high exactly on the clocks that move a word. While `mem_ce_n` is low, `mem_lb_n` (lane bits 7:0) equals the inverse of `req_be[0]` and `mem_ub_n` (lane bits 15:8) equals the inverse of `req_be[1]`. A lane whose enable is 0 keeps its old content.
- R6: `mem_ce_n` never stays low for more than `CE_MAX_NS / CLK_PERIOD_NS` consecutive clocks.
- R7: Between two bursts, `mem_ce_n` stays high for at least `ceil(GAP_NS / CLK_PERIOD_NS)` clocks, with a minimum of one.
- R8: A transaction whose words do not fit in one burst is continued in further bursts. Each burst begins at the address after the last moved word, and the total number of words moved equals `req_len + 1`.
- R9: `req_ready` is high only while `mem_ce_n` is high and no transaction is in progress. It rises exactly `GAP + 1` clocks after the final word of a transaction moves.
- R10: Word addresses advance modulo 2^21, so the address after 0x1FFFFF is 0x000000.
- R11: `mem_oe_n` is low only on the data clocks of a read burst. It is high during the address strobe, during write bursts and whenever `mem_ce_n` is high, and it is never low while `mem_dq_oe` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and memory bus clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Transaction offered |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | First word address |
| req_len | input | LEN_W | Word count minus one |
| req_be | input | 2 | Byte enables, bit 0 = low lane, bit 1 = high lane |
| wr_data | input | 16 | Current write word |
| wr_take | output | 1 | Current write word consumed on this clock |
| rd_valid | output | 1 | Read word present |
| rd_data | output | 16 | Read word |
| rd_last | output | 1 | Final read word of the transaction |
| mem_clk_en | output | 1 | Memory clock gate, high while chip enable is low |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_adv_n | output | 1 | Address strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lb_n | output | 1 | Low byte lane enable, active low |
| mem_ub_n | output | 1 | High byte lane enable, active low |
| mem_addr | output | 21 | Word address |
| mem_dq_o | output | 16 | Write data to the bus |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_i | input | 16 | Read data from the bus |
| mem_wait | input | 1 | Memory not ready, active high |

## Verification
The bench sets a 10 ns clock with an 80 ns chip-enable budget and a 25 ns gap. The controller therefore closes a burst after 8 low clocks and waits 3 high clocks before the next one. With a memory model that holds WAIT for three clocks of latency and optionally stalls every third clock, any transfer above four words must split, and stalls land both in mid-burst and on the closing clock. A startup delay of 6 clocks and a word-count width of 6 bits keep the boot phase and the longest transaction short enough that wrap-around at the top of the address space, single-word transfers and partial-lane writes all fit in one run.

// File: rtl/psram_pkg.sv
package psram_pkg;
    typedef enum logic [2:0] {
        ST_BOOT,
        ST_IDLE,
        ST_ADDR,
        ST_XFER,
        ST_GAP
    } ctl_state_e;
endpackage

// File: rtl/psram_down_timer.sv
// Loadable down-counter; busy while non-zero.
module psram_down_timer #(
    parameter int W       = 8,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         busy
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= W'(RST_VAL);
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/psram_lane_map.sv
// Byte-lane strobes and data drive enable, derived from registered state only.
module psram_lane_map #(
    parameter int LANES = 2
) (
    input  logic             ce_n,
    input  logic             wr,
    input  logic [LANES-1:0] be,
    output logic [LANES-1:0] lane_n,
    output logic             dq_oe
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_n[i] = ce_n | ~be[i];
    end
    assign dq_oe = ~ce_n & wr;
endmodule

// File: rtl/psram_burst_ctl.sv
module psram_burst_ctl
    import psram_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 10,
    parameter int CE_MAX_NS     = 8000,
    parameter int GAP_NS        = 5,
    parameter int STARTUP_CYC   = 150,
    parameter int ADDR_W        = 21,
    parameter int DATA_W        = 16,
    parameter int LEN_W         = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [LEN_W-1:0]    req_len,
    input  logic [DATA_W/8-1:0] req_be,
    input  logic [DATA_W-1:0]   wr_data,
    output logic                wr_take,
    output logic                rd_valid,
    output logic [DATA_W-1:0]   rd_data,
    output logic                rd_last,
    output logic                mem_clk_en,
    output logic                mem_ce_n,
    output logic                mem_adv_n,
    output logic                mem_oe_n,
    output logic                mem_we_n,
    output logic                mem_lb_n,
    output logic                mem_ub_n,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]   mem_dq_o,
    output logic                mem_dq_oe,
    input  logic [DATA_W-1:0]   mem_dq_i,
    input  logic                mem_wait
);
    localparam int LANES    = DATA_W / 8;
    localparam int LOW_MAX  = CE_MAX_NS / CLK_PERIOD_NS;
    localparam int GAP_RAW  = (GAP_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
    localparam int GAP_CYC  = (GAP_RAW < 1) ? 1 : GAP_RAW;
    localparam int LOW_W    = $clog2(LOW_MAX + 1);
    localparam int GAP_W    = $clog2(GAP_CYC + 1);
    localparam int BOOT_W   = $clog2(STARTUP_CYC + 2);

    typedef struct packed {
        ctl_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  left;
        logic              wr;
        logic [LANES-1:0]  be;
        logic [LOW_W-1:0]  low;
        logic              fin;
        logic              ce_n;
        logic              adv_n;
        logic              oe_n;
        logic              we_n;
        logic              clk_en;
        logic              rd_valid;
        logic              rd_last;
        logic [DATA_W-1:0] rd_data;
    } ctl_s;

    ctl_s s_d, s_q;
    logic boot_busy, gap_busy, gap_load, launch, beat, burst_end;
    logic [LANES-1:0] lane_n;

    psram_down_timer #(.W(BOOT_W), .RST_VAL(STARTUP_CYC)) u_boot (
        .clk(clk), .rst_n(rst_n), .load(1'b0), .load_val('0), .busy(boot_busy)
    );

    psram_down_timer #(.W(GAP_W), .RST_VAL(0)) u_gap (
        .clk(clk), .rst_n(rst_n), .load(gap_load),
        .load_val(GAP_W'(GAP_CYC - 1)), .busy(gap_busy)
    );

    psram_lane_map #(.LANES(LANES)) u_lanes (
        .ce_n(s_q.ce_n), .wr(s_q.wr), .be(s_q.be), .lane_n(lane_n), .dq_oe(mem_dq_oe)
    );

    assign beat      = (s_q.st == ST_XFER) && !mem_wait;
    assign burst_end = (beat && (s_q.left == '0)) || (s_q.low == LOW_W'(LOW_MAX));

    always_comb begin
        s_d          = s_q;
        s_d.adv_n    = 1'b1;
        s_d.rd_valid = 1'b0;
        s_d.rd_last  = 1'b0;
        gap_load     = 1'b0;
        launch       = 1'b0;
        unique case (s_q.st)
            ST_BOOT: if (!boot_busy) s_d.st = ST_IDLE;
            ST_IDLE: if (req_valid) begin
                s_d.addr = req_addr;
                s_d.left = req_len;
                s_d.wr   = req_write;
                s_d.be   = req_be;
                launch   = 1'b1;
            end
            ST_ADDR: begin
                s_d.st   = ST_XFER;
                s_d.low  = s_q.low + 1'b1;
                s_d.oe_n = s_q.wr;
            end
            ST_XFER: begin
                if (beat) begin
                    s_d.addr = s_q.addr + 1'b1;
                    if (s_q.left != '0) s_d.left = s_q.left - 1'b1;
                    if (!s_q.wr) begin
                        s_d.rd_valid = 1'b1;
                        s_d.rd_data  = mem_dq_i;
                        s_d.rd_last  = (s_q.left == '0);
                    end
                end
                if (burst_end) begin
                    s_d.st     = ST_GAP;
                    s_d.fin    = beat && (s_q.left == '0);
                    s_d.ce_n   = 1'b1;
                    s_d.oe_n   = 1'b1;
                    s_d.we_n   = 1'b1;
                    s_d.clk_en = 1'b0;
                    gap_load   = 1'b1;
                end else begin
                    s_d.low = s_q.low + 1'b1;
                end
            end
            ST_GAP: if (!gap_busy) begin
                if (s_q.fin) s_d.st = ST_IDLE;
                else         launch = 1'b1;
            end
            default: s_d.st = ST_IDLE;
        endcase
        if (launch) begin
            s_d.st     = ST_ADDR;
            s_d.ce_n   = 1'b0;
            s_d.adv_n  = 1'b0;
            s_d.we_n   = ~s_d.wr;
            s_d.oe_n   = 1'b1;
            s_d.low    = LOW_W'(1);
            s_d.clk_en = 1'b1;
            s_d.fin    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.st     <= ST_BOOT;
            s_q.ce_n   <= 1'b1;
            s_q.adv_n  <= 1'b1;
            s_q.oe_n   <= 1'b1;
            s_q.we_n   <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready  = (s_q.st == ST_IDLE);
    assign wr_take    = beat && s_q.wr;
    assign rd_valid   = s_q.rd_valid;
    assign rd_data    = s_q.rd_data;
    assign rd_last    = s_q.rd_last;
    assign mem_clk_en = s_q.clk_en;
    assign mem_ce_n   = s_q.ce_n;
    assign mem_adv_n  = s_q.adv_n;
    assign mem_oe_n   = s_q.oe_n;
    assign mem_we_n   = s_q.we_n;
    assign mem_lb_n   = lane_n[0];
    assign mem_ub_n   = lane_n[LANES-1];
    assign mem_addr   = s_q.addr;
    assign mem_dq_o   = wr_data;
endmodule

// File: rtl/psram_burst_chk.sv
module psram_burst_chk #(
    parameter int CLK_PERIOD_NS = 10,
    parameter int CE_MAX_NS     = 8000,
    parameter int GAP_NS        = 5,
    parameter int STARTUP_CYC   = 150
) (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic wr_take,
    input logic rd_valid,
    input logic rd_last,
    input logic mem_ce_n,
    input logic mem_adv_n,
    input logic mem_oe_n,
    input logic mem_we_n,
    input logic mem_dq_oe,
    input logic mem_wait
);
    localparam int LOW_MAX = CE_MAX_NS / CLK_PERIOD_NS;
    localparam int GAP_RAW = (GAP_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
    localparam int GAP_CYC = (GAP_RAW < 1) ? 1 : GAP_RAW;

    int unsigned low_q, high_q, since_q, low_cur;
    logic seen_low_q;

    assign low_cur = mem_ce_n ? 0 : low_q + 1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_q      <= 0;
            high_q     <= 0;
            since_q    <= 0;
            seen_low_q <= 1'b0;
        end else begin
            low_q      <= low_cur;
            high_q     <= mem_ce_n ? ((high_q < 1000000) ? high_q + 1 : high_q) : 0;
            since_q    <= (since_q < STARTUP_CYC) ? since_q + 1 : since_q;
            seen_low_q <= seen_low_q | ~mem_ce_n;
        end
    end

    // R1
    boot_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_q < STARTUP_CYC) |-> (mem_ce_n && !req_ready));
    // R2
    adv_in_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_adv_n |-> !mem_ce_n);
    // R2
    adv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_adv_n |=> mem_adv_n);
    // R3
    take_when_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_take |-> (!mem_wait && !mem_ce_n && mem_adv_n));
    // R4
    last_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_last |-> rd_valid);
    // R6
    low_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        low_cur <= LOW_MAX);
    // R7
    gap_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mem_ce_n) && seen_low_q) |-> (high_q >= GAP_CYC));
    // R9
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> mem_ce_n);
    // R11
    oe_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_we_n && !mem_ce_n && mem_adv_n && !mem_dq_oe));
endmodule

bind psram_burst_ctl psram_burst_chk #(
    .CLK_PERIOD_NS(CLK_PERIOD_NS),
    .CE_MAX_NS(CE_MAX_NS),
    .GAP_NS(GAP_NS),
    .STARTUP_CYC(STARTUP_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .wr_take(wr_take),
    .rd_valid(rd_valid), .rd_last(rd_last), .mem_ce_n(mem_ce_n),
    .mem_adv_n(mem_adv_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_oe(mem_dq_oe), .mem_wait(mem_wait)
);

// File: tb/sim_psram_burst_ctl.sv
`timescale 1ns/1ps
module sim_psram_burst_ctl;
    localparam int LOW_LIM = 8;
    localparam int GAP     = 3;
    localparam int BOOT    = 6;
    localparam int LAT     = 3;
    localparam int LW      = 6;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, req_write = 0;
    logic [20:0] req_addr = '0;
    logic [LW-1:0] req_len = '0;
    logic [1:0] req_be = '0;
    logic [15:0] wr_data = '0, mem_dq_i = '0;
    logic mem_wait = 0;
    logic req_ready, wr_take, rd_valid, rd_last, mem_clk_en, mem_ce_n, mem_adv_n;
    logic mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe;
    logic [15:0] rd_data, mem_dq_o;
    logic [20:0] mem_addr;

    psram_burst_ctl #(.CLK_PERIOD_NS(10), .CE_MAX_NS(80), .GAP_NS(25),
                      .STARTUP_CYC(BOOT), .LEN_W(LW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_len(req_len), .req_be(req_be),
        .wr_data(wr_data), .wr_take(wr_take), .rd_valid(rd_valid), .rd_data(rd_data),
        .rd_last(rd_last), .mem_clk_en(mem_clk_en), .mem_ce_n(mem_ce_n),
        .mem_adv_n(mem_adv_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_addr(mem_addr),
        .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i),
        .mem_wait(mem_wait)
    );

    always #5 clk = ~clk;

    int total = 0, bad = 0, cyc = 0;
    bit finished = 0;
    logic [15:0] mem [int];
    logic [15:0] gold [int];
    logic [15:0] wq[$];
    logic [15:0] rdq[$];
    bit lastq[$];
    int wptr = 0;
    bit stall_en = 0, txn_new = 0, p_write = 0, mwrite = 0;
    logic [20:0] p_addr = '0, exp_addr = '0, maddr = '0;
    logic [1:0] p_be = '0;
    int p_len = 0, remaining = 0, beats_done = 0, lat_cnt = 0;
    int low_run = 0, high_run = 0, last_beat_cyc = -1;
    bit seen_low = 0, prev_adv = 1, prev_ready = 0;

    function automatic logic [15:0] dflt(logic [20:0] a);
        return 16'hA5C3 ^ a[15:0];
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Behavioural memory and per-clock reference checks
    always @(negedge clk) begin
        if (rst_n) begin
            bit is_beat;
            cyc++;
            is_beat = 0;
            if (rd_valid) begin
                if (rdq.size() == 0) chk(0, "R4 unexpected read word", rd_data, 0);
                else begin
                    logic [15:0] ew; bit el;
                    ew = rdq.pop_front(); el = lastq.pop_front();
                    chk(rd_data == ew, "R4 read data", rd_data, ew);
                    chk(rd_last == el, "R4 read last", rd_last, el);
                end
            end else chk(rd_last == 0, "R4 last without valid", rd_last, 0);
            if (!mem_ce_n) begin
                low_run++;
                chk(low_run <= LOW_LIM, "R6 chip enable low run", low_run, LOW_LIM);
                if (low_run == 1 && seen_low)
                    chk(high_run >= GAP, "R7 refresh gap", high_run, GAP);
                seen_low = 1;
                high_run = 0;
                chk(mem_lb_n == ~mwrite_be(0), "R5 low lane strobe", mem_lb_n, ~p_be[0]);
                chk(mem_ub_n == ~mwrite_be(1), "R5 high lane strobe", mem_ub_n, ~p_be[1]);
            end else begin
                low_run = 0;
                high_run++;
                chk(mem_adv_n == 1, "R2 strobe outside burst", mem_adv_n, 1);
            end
            if (req_ready) chk(remaining == 0 && mem_ce_n, "R9 ready while busy", remaining, 0);
            if (req_ready && !prev_ready && last_beat_cyc >= 0)
                chk(cyc - last_beat_cyc == GAP + 1, "R9 ready return delay", cyc - last_beat_cyc, GAP + 1);
            prev_ready = req_ready;
            mem_wait = 0;
            mem_dq_i = 16'h0;
            if (!mem_ce_n && !mem_adv_n) begin
                chk(prev_adv == 1, "R2 strobe length", prev_adv, 1);
                if (txn_new) begin
                    txn_new = 0;
                    exp_addr = p_addr; remaining = p_len; mwrite = p_write; beats_done = 0;
                end
                chk(mem_addr == exp_addr, "R8 burst start address", mem_addr, exp_addr);
                chk(mem_we_n == ~mwrite, "R2 direction", mem_we_n, ~mwrite);
                chk(mem_oe_n == 1, "R11 oe in strobe", mem_oe_n, 1);
                maddr = mem_addr;
                lat_cnt = LAT;
                mem_wait = 1;
            end else if (!mem_ce_n) begin
                chk(mem_oe_n == mwrite, "R11 output enable", mem_oe_n, mwrite);
                chk(mem_dq_oe == mwrite, "R5 data drive", mem_dq_oe, mwrite);
                if (lat_cnt > 0) begin mem_wait = 1; lat_cnt--; end
                else if (stall_en && (cyc % 3 == 0)) mem_wait = 1;
                else is_beat = 1;
            end
            if (wptr < wq.size()) wr_data = wq[wptr];
            if (is_beat) begin
                chk(remaining > 0, "R8 extra word", remaining, 0);
                if (mwrite) begin
                    logic [15:0] o;
                    chk(mem_dq_o == wr_data, "R5 write data", mem_dq_o, wr_data);
                    o = mem.exists(maddr) ? mem[maddr] : dflt(maddr);
                    if (!mem_lb_n) o[7:0] = mem_dq_o[7:0];
                    if (!mem_ub_n) o[15:8] = mem_dq_o[15:8];
                    mem[maddr] = o;
                    wptr++;
                end else begin
                    mem_dq_i = mem.exists(maddr) ? mem[maddr] : dflt(maddr);
                end
                maddr++; exp_addr++; remaining--; beats_done++;
                if (remaining == 0) last_beat_cyc = cyc;
            end
            prev_adv = mem_adv_n;
            #1;
            chk(wr_take == (is_beat && mwrite), "R3 take only on ready clock", wr_take, is_beat && mwrite);
        end
    end

    function automatic logic mwrite_be(int i);
        return p_be[i];
    endfunction

    task automatic issue(bit w, logic [20:0] a, int n, logic [1:0] be, bit st);
        while (req_ready !== 1) @(negedge clk);
        stall_en = st; p_addr = a; p_len = n; p_write = w; p_be = be;
        wq.delete(); wptr = 0;
        for (int i = 0; i < n; i++) begin
            logic [20:0] ai;
            logic [15:0] wd, o;
            ai = a + 21'(i);
            wd = {a[7:0] + 8'(i), 8'h3C ^ 8'(i * 7)};
            wq.push_back(wd);
            o = gold.exists(ai) ? gold[ai] : dflt(ai);
            if (w) begin
                if (be[0]) o[7:0] = wd[7:0];
                if (be[1]) o[15:8] = wd[15:8];
                gold[ai] = o;
            end else begin
                rdq.push_back(o);
                lastq.push_back(i == n - 1);
            end
        end
        txn_new = 1;
        req_valid = 1; req_write = w; req_addr = a; req_len = LW'(n - 1); req_be = be;
        @(negedge clk);
        req_valid = 0;
        #2;
        while (!(txn_new == 0 && remaining == 0 && req_ready === 1)) @(negedge clk);
        chk(beats_done == n, "R8 word count", beats_done, n);
        chk(rdq.size() == 0, "R4 all read words returned", rdq.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(mem_ce_n == 1 && mem_adv_n == 1 && req_ready == 0 && rd_valid == 0,
            "R1 reset state", {mem_ce_n, mem_adv_n, req_ready, rd_valid}, 4'b1100);
        rst_n = 1;
        for (int p = 1; p <= BOOT + 1; p++) begin
            @(negedge clk);
            #2;
            chk(mem_ce_n == 1, "R1 boot chip enable", mem_ce_n, 1);
            chk(req_ready == (p >= BOOT + 1), "R1 boot ready", req_ready, p >= BOOT + 1);
        end
        issue(1, 21'h000100, 3, 2'b11, 0);   // R5 short write
        issue(0, 21'h000100, 3, 2'b11, 0);   // R4 read back
        issue(1, 21'h000200, 10, 2'b11, 1);  // R6 R7 R8 split write with stalls
        issue(0, 21'h000200, 10, 2'b11, 1);  // R3 R8 split read with stalls
        issue(1, 21'h000100, 1, 2'b01, 0);   // R5 low lane only
        issue(1, 21'h000101, 1, 2'b10, 1);   // R5 high lane only
        issue(0, 21'h000100, 2, 2'b11, 0);   // R5 merged lanes read back
        issue(1, 21'h1FFFFD, 6, 2'b11, 1);   // R10 wrap across a split
        issue(0, 21'h1FFFFD, 6, 2'b11, 0);   // R10 read across wrap
        issue(0, 21'h000203, 1, 2'b11, 0);   // R4 single word
        issue(0, 21'h000300, 20, 2'b11, 1);  // R6 R8 long read
        issue(0, 21'h000104, 4, 2'b11, 0);   // R6 exact window fill
        repeat (5) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule